// File: doc/BRIEF.md
# Single-Wire Monitor Entry Controller

This block decides whether a chip enters its debug monitor mode. It then runs the security handshake that follows entry, over one shared serial wire. Entry happens in one of two ways, and both need the entry conditions: high voltage on the interrupt pin together with the strap pins. The first is the first clock after reset is released. The second is a software-interrupt request made later in normal operation. Once in the mode, the block listens on the wire for a fixed number of key bytes (8N1 framing, least significant bit first, mid-bit sampling). It compares each byte in order with a stored key.

After the last key byte, the block pulls the wire low for ten bit periods as a break, and then reports that it is ready for commands. Access is unlocked only if every key byte matched. The unlock state then holds until the next reset. The wire is wired-OR with an external pullup, so the block only ever enables a pull-down. While the mode is active, the block also remaps the vector page from 0xFF to 0xFE. It disables the watchdog while high voltage is seen on the interrupt or reset pin, and bypasses the clock generator while high voltage is seen on the interrupt pin.

Top module: `monEntry`

## Requirements
- R1: No break is driven and `ready` stays 0 until exactly KEY_LEN (8) complete key bytes have been received after entry.
- R2: The break is a continuous `lineLow` pulse of BRK_BITS*CLKS_PER_BIT clock cycles (10 bit periods). It starts after the final key byte, and `ready` rises when the pulse ends.
- R3: `lineLow` is the only drive of the wire, and it is 1 only during the break. It is 0 in normal mode and after the break.
- R4: `vecPage` is 8'hFE while `monActive` is 1, and 8'hFF otherwise.
- R5: `wdogOff` is 1 exactly when `monActive` is 1 and `hvIrq` or `hvRst` is 1.
- R6: `clkBypass` is 1 exactly when `monActive` is 1 and `hvIrq` is 1. `hvRst` has no effect on it.
- R7: Monitor mode is entered when `hvIrq` and `strapOk` are both 1 either in the first clock after reset release or together with a `swiReq` pulse. Without these conditions, `monActive` stays 0 until reset.
- R8: `unlocked` becomes 1 only if received byte i equals `keyBytes[8*i+7:8*i]` for every i from 0 to 7, with byte 0 sent first. After a mismatch it stays 0, and once set it stays 1, until the next reset.
- R9: Each key byte is a low start bit, 8 data bits LSB first and a high stop bit, each CLKS_PER_BIT clocks long. A byte whose stop bit samples low is discarded and is not counted.
- R10: Line activity after the last key byte (during the break and in the ready state) does not start a new key sequence. It changes neither `unlocked` nor `ready`, and it produces no further break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset (the reset pin) |
| hvIrq | input | 1 | High voltage detected on the interrupt pin |
| hvRst | input | 1 | High voltage detected on the reset pin |
| strapOk | input | 1 | Remaining strap pins hold the entry levels |
| swiReq | input | 1 | Software-interrupt entry request |
| lineIn | input | 1 | Level of the shared serial wire |
| keyBytes | input | 64 | Stored key; byte i in bits [8i+7:8i] |
| lineLow | output | 1 | Pull-down enable for the shared wire |
| monActive | output | 1 | Monitor mode is active |
| ready | output | 1 | Break sent, ready for commands |
| unlocked | output | 1 | All key bytes matched |
| vecPage | output | 8 | Page byte used for the reset, software-interrupt and break vectors |
| wdogOff | output | 1 | Watchdog disable |
| clkBypass | output | 1 | Clock-generator bypass |

## Verification
A wrong byte count or a bad compare register shows at the ports within one byte time. The break starts after the wrong number of bytes, or `unlocked` disagrees with the key pattern that was sent. Both are seen within one break length of the last byte. A wrong mode state shows in the very next cycle on `vecPage`, `wdogOff` and `clkBypass`. A receiver that is not gated off after the key phase shows up as a second break pulse or a changed `unlocked` once extra bytes are sent in the ready state.

// File: rtl/monEntryPkg.sv
package monEntryPkg;
  typedef enum logic [1:0] {
    S_OFF = 2'd0,
    S_KEY = 2'd1,
    S_BRK = 2'd2,
    S_RDY = 2'd3
  } monStateT;

  typedef struct packed {
    logic clrKey;  // hold key tracking cleared
    logic rxEn;    // receiver may listen to the wire
    logic brkEn;   // break timer runs, wire pulled low
  } monStrobeT;
endpackage

// File: rtl/monDatapath.sv
module monDatapath
  import monEntryPkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int KEY_LEN = 8,
  parameter int BRK_BITS = 10
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  monStrobeT              st,
  input  logic                   lineIn,
  input  logic [KEY_LEN*8-1:0]   keyBytes,
  output logic                   keyDone,
  output logic                   keyMatch,
  output logic                   brkLast
);
  localparam int CNT_W   = $clog2(CLKS_PER_BIT) + 1;
  localparam int HALF    = CLKS_PER_BIT / 2;
  localparam int IDX_W   = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
  localparam int BRK_CYC = BRK_BITS * CLKS_PER_BIT;
  localparam int BRK_W   = $clog2(BRK_CYC + 1);

  logic             lineQ, lineQ2;
  logic             rxBusy, byteValid;
  logic [CNT_W-1:0] bitCnt;
  logic [3:0]       bitIdx;
  logic [7:0]       shiftReg;
  logic [IDX_W-1:0] keyIdx;
  logic             mismatch;
  logic [BRK_W-1:0] brkCnt;
  logic [7:0]       expByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineQ  <= 1'b1;
      lineQ2 <= 1'b1;
    end else begin
      lineQ  <= lineIn;
      lineQ2 <= lineQ;
    end
  end

  // 8N1 receiver, LSB first, samples near mid-bit
  always_ff @(posedge clk) begin
    if (!rstN || !st.rxEn) begin
      rxBusy    <= 1'b0;
      byteValid <= 1'b0;
      bitCnt    <= '0;
      bitIdx    <= '0;
      shiftReg  <= '0;
    end else begin
      byteValid <= 1'b0;
      if (!rxBusy) begin
        if (lineQ2 && !lineQ) begin
          rxBusy <= 1'b1;
          bitCnt <= CNT_W'(HALF - 1);
          bitIdx <= '0;
        end
      end else if (bitCnt != '0) begin
        bitCnt <= bitCnt - 1'b1;
      end else begin
        bitCnt <= CNT_W'(CLKS_PER_BIT - 1);
        bitIdx <= bitIdx + 1'b1;
        if (bitIdx == 4'd0) begin
          if (lineQ) rxBusy <= 1'b0;          // false start
        end else if (bitIdx <= 4'd8) begin
          shiftReg <= {lineQ, shiftReg[7:1]};
        end else begin
          rxBusy    <= 1'b0;
          byteValid <= lineQ;                 // drop on framing error
        end
      end
    end
  end

  assign expByte = keyBytes[8*int'(keyIdx) +: 8];

  always_ff @(posedge clk) begin
    if (!rstN || st.clrKey) begin
      keyIdx   <= '0;
      mismatch <= 1'b0;
      keyDone  <= 1'b0;
    end else if (byteValid && !keyDone) begin
      if (shiftReg != expByte) mismatch <= 1'b1;
      if (keyIdx == IDX_W'(KEY_LEN - 1)) keyDone <= 1'b1;
      else keyIdx <= keyIdx + 1'b1;
    end
  end

  assign keyMatch = !mismatch;

  always_ff @(posedge clk) begin
    if (!rstN || !st.brkEn) brkCnt <= '0;
    else brkCnt <= brkCnt + 1'b1;
  end

  assign brkLast = st.brkEn && (brkCnt == BRK_W'(BRK_CYC - 1));
endmodule

// File: rtl/monControl.sv
module monControl
  import monEntryPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      hvIrq,
  input  logic      hvRst,
  input  logic      strapOk,
  input  logic      swiReq,
  input  logic      keyDone,
  input  logic      keyMatch,
  input  logic      brkLast,
  output monStrobeT st,
  output logic      lineLow,
  output logic      monActive,
  output logic      ready,
  output logic      unlocked,
  output logic [7:0] vecPage,
  output logic      wdogOff,
  output logic      clkBypass
);
  monStateT state, stateNext;
  logic     firstCyc;
  logic     entryCond;

  assign entryCond = hvIrq && strapOk;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_OFF: if (entryCond && (firstCyc || swiReq)) stateNext = S_KEY;
      S_KEY: if (keyDone) stateNext = S_BRK;
      S_BRK: if (brkLast) stateNext = S_RDY;
      S_RDY: stateNext = S_RDY;
      default: stateNext = S_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_OFF;
      firstCyc <= 1'b1;
    end else begin
      state    <= stateNext;
      firstCyc <= 1'b0;
    end
  end

  always_comb begin
    st.clrKey = (state == S_OFF);
    st.rxEn   = (state == S_KEY);
    st.brkEn  = (state == S_BRK);
  end

  assign monActive = (state != S_OFF);
  assign lineLow   = (state == S_BRK);
  assign ready     = (state == S_RDY);
  assign unlocked  = monActive && keyDone && keyMatch;
  assign vecPage   = monActive ? 8'hFE : 8'hFF;
  assign wdogOff   = monActive && (hvIrq || hvRst);
  assign clkBypass = monActive && hvIrq;
endmodule

// File: rtl/monEntry.sv
module monEntry
  import monEntryPkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int BRK_BITS = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hvIrq,
  input  logic        hvRst,
  input  logic        strapOk,
  input  logic        swiReq,
  input  logic        lineIn,
  input  logic [63:0] keyBytes,
  output logic        lineLow,
  output logic        monActive,
  output logic        ready,
  output logic        unlocked,
  output logic [7:0]  vecPage,
  output logic        wdogOff,
  output logic        clkBypass
);
  localparam int KEY_LEN = 8;

  monStrobeT st;
  logic      keyDone, keyMatch, brkLast;

  monDatapath #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .KEY_LEN(KEY_LEN),
    .BRK_BITS(BRK_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .lineIn(lineIn), .keyBytes(keyBytes),
    .keyDone(keyDone), .keyMatch(keyMatch), .brkLast(brkLast)
  );

  monControl u_ctl (
    .clk(clk), .rstN(rstN), .hvIrq(hvIrq), .hvRst(hvRst), .strapOk(strapOk),
    .swiReq(swiReq), .keyDone(keyDone), .keyMatch(keyMatch), .brkLast(brkLast),
    .st(st), .lineLow(lineLow), .monActive(monActive), .ready(ready),
    .unlocked(unlocked), .vecPage(vecPage), .wdogOff(wdogOff),
    .clkBypass(clkBypass)
  );
endmodule

// File: rtl/monEntryChk.sv
module monEntryChk #(
  parameter int CLKS_PER_BIT = 16,
  parameter int BRK_BITS = 10
) (
  input logic       clk,
  input logic       rstN,
  input logic       hvIrq,
  input logic       lineLow,
  input logic       monActive,
  input logic       ready,
  input logic       unlocked,
  input logic [7:0] vecPage,
  input logic       wdogOff,
  input logic       clkBypass
);
  localparam int BRK_CYC = BRK_BITS * CLKS_PER_BIT;
  localparam int W = $clog2(BRK_CYC + 2) + 1;

  logic [W-1:0] lowRun;

  always_ff @(posedge clk) begin
    if (!rstN) lowRun <= '0;
    else if (lineLow) lowRun <= lowRun + 1'b1;
    else lowRun <= '0;
  end

  AST_BRK_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lineLow) |-> (lowRun == W'(BRK_CYC))); // R2
  AST_READY_AFTER_BRK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(lineLow)); // R2
  AST_NO_PULL_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    (!monActive || ready) |-> !lineLow); // R3
  AST_READY_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (vecPage == 8'hFE)); // R4
  AST_BYPASS_WDOG: assert property (@(posedge clk) disable iff (!rstN)
    clkBypass |-> wdogOff); // R5
  AST_BYPASS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    clkBypass |-> hvIrq); // R6
  AST_UNLOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    unlocked |=> unlocked); // R8
endmodule

bind monEntry monEntryChk #(.CLKS_PER_BIT(CLKS_PER_BIT), .BRK_BITS(BRK_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .hvIrq(hvIrq), .lineLow(lineLow),
  .monActive(monActive), .ready(ready), .unlocked(unlocked),
  .vecPage(vecPage), .wdogOff(wdogOff), .clkBypass(clkBypass)
);

// File: tb/monEntry_bench.sv
`timescale 1ns/1ps
module monEntry_bench;
  localparam int CPB = 8;
  localparam int BRK_BITS = 10;
  localparam int BRK_CYC = CPB * BRK_BITS;
  localparam logic [63:0] KEY = 64'h5A3C_96E1_0F7B_C428;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hvIrq = 1'b0, hvRst = 1'b0, strapOk = 1'b0, swiReq = 1'b0;
  logic lineHost = 1'b1;
  logic lineIn;
  logic lineLow, monActive, ready, unlocked, wdogOff, clkBypass;
  logic [7:0] vecPage;

  int total = 0, bad = 0;
  int run = 0, lastLen = 0, pulses = 0;

  always #4 clk = ~clk;

  assign lineIn = lineHost & ~lineLow;

  monEntry #(.CLKS_PER_BIT(CPB), .BRK_BITS(BRK_BITS)) u_monEntry (
    .clk(clk), .rstN(rstN), .hvIrq(hvIrq), .hvRst(hvRst), .strapOk(strapOk),
    .swiReq(swiReq), .lineIn(lineIn), .keyBytes(KEY), .lineLow(lineLow),
    .monActive(monActive), .ready(ready), .unlocked(unlocked),
    .vecPage(vecPage), .wdogOff(wdogOff), .clkBypass(clkBypass)
  );

  always @(negedge clk) begin
    if (lineLow) run = run + 1;
    else if (run != 0) begin
      lastLen = run;
      pulses = pulses + 1;
      run = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic strap, input logic irq);
    strapOk = strap; hvIrq = irq; hvRst = 1'b0; swiReq = 1'b0; lineHost = 1'b1;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    pulses = 0; lastLen = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic stopBit);
    lineHost = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      lineHost = b[i];
      repeat (CPB) @(negedge clk);
    end
    lineHost = stopBit;
    repeat (CPB) @(negedge clk);
    lineHost = 1'b1;
    repeat (CPB) @(negedge clk);
  endtask

  function automatic logic [7:0] keyByte(input int i);
    return KEY[8*i +: 8];
  endfunction

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R7: no entry conditions, normal mode
    doReset(1'b0, 1'b0);
    check(monActive == 1'b0, "R7 no entry", monActive, 0);
    check(vecPage == 8'hFF, "R4 normal page", vecPage, 8'hFF);
    check(lineLow == 1'b0, "R3 idle no pull", lineLow, 0);
    for (int c = 0; c < 4; c++) begin
      hvIrq = c[1]; hvRst = c[0];
      @(negedge clk);
      check(wdogOff == 1'b0, "R5 off in normal", wdogOff, 0);
      check(clkBypass == 1'b0, "R6 off in normal", clkBypass, 0);
    end
    hvIrq = 1'b1; strapOk = 1'b0; swiReq = 1'b1; @(negedge clk); swiReq = 1'b0;
    @(negedge clk);
    check(monActive == 1'b0, "R7 swi without strap", monActive, 0);

    // R7: reset entry, then R1/R2/R8 with a full matching key
    doReset(1'b1, 1'b1);
    check(monActive == 1'b1, "R7 reset entry", monActive, 1);
    check(vecPage == 8'hFE, "R4 monitor page", vecPage, 8'hFE);
    check(ready == 1'b0 && unlocked == 1'b0, "R8 reset state", unlocked, 0);
    for (int c = 0; c < 4; c++) begin
      hvIrq = c[1]; hvRst = c[0];
      @(negedge clk);
      check(wdogOff == (c[1] | c[0]), "R5 sweep", wdogOff, c[1] | c[0]);
      check(clkBypass == c[1], "R6 sweep", clkBypass, c[1]);
    end
    hvIrq = 1'b1; hvRst = 1'b0;
    for (int i = 0; i < 7; i++) sendByte(keyByte(i), 1'b1);
    repeat (3 * CPB) @(negedge clk);
    check(pulses == 0 && run == 0, "R1 no break after 7", pulses, 0);
    check(ready == 1'b0, "R1 not ready after 7", ready, 0);
    sendByte(keyByte(7), 1'b1);
    repeat (BRK_CYC + 20) @(negedge clk);
    check(pulses == 1, "R2 one break", pulses, 1);
    check(lastLen == BRK_CYC, "R2 break length", lastLen, BRK_CYC);
    check(ready == 1'b1, "R2 ready", ready, 1);
    check(unlocked == 1'b1, "R8 all match", unlocked, 1);
    check(lineLow == 1'b0, "R3 released", lineLow, 0);
    for (int i = 0; i < 8; i++) sendByte(8'h00, 1'b1);
    repeat (20) @(negedge clk);
    check(pulses == 1, "R10 no second break", pulses, 1);
    check(unlocked == 1'b1 && ready == 1'b1, "R10 unlock kept", unlocked, 1);

    // R8: single-byte mismatch at every position
    for (int p = 0; p < 8; p++) begin
      doReset(1'b1, 1'b1);
      for (int i = 0; i < 8; i++) sendByte(keyByte(i) ^ ((i == p) ? 8'h80 : 8'h00), 1'b1);
      repeat (BRK_CYC + 20) @(negedge clk);
      check(pulses == 1 && lastLen == BRK_CYC, "R2 break on mismatch", lastLen, BRK_CYC);
      check(ready == 1'b1, "R2 ready on mismatch", ready, 1);
      check(unlocked == 1'b0, "R8 mismatch locked", unlocked, 0);
      for (int i = 0; i < 8; i++) sendByte(keyByte(i), 1'b1);
      repeat (20) @(negedge clk);
      check(unlocked == 1'b0 && pulses == 1, "R10 relock ignored", unlocked, 0);
    end

    // R9: bit order, reversed first byte must mismatch
    doReset(1'b1, 1'b1);
    sendByte({keyByte(0)[0], keyByte(0)[1], keyByte(0)[2], keyByte(0)[3],
              keyByte(0)[4], keyByte(0)[5], keyByte(0)[6], keyByte(0)[7]}, 1'b1);
    for (int i = 1; i < 8; i++) sendByte(keyByte(i), 1'b1);
    repeat (BRK_CYC + 20) @(negedge clk);
    check(unlocked == 1'b0 && ready == 1'b1, "R9 msb-first rejected", unlocked, 0);

    // R9: framing-error byte is not counted
    doReset(1'b1, 1'b1);
    sendByte(8'hA5, 1'b0);
    for (int i = 0; i < 8; i++) sendByte(keyByte(i), 1'b1);
    repeat (BRK_CYC + 20) @(negedge clk);
    check(pulses == 1, "R9 framing byte dropped", pulses, 1);
    check(unlocked == 1'b1, "R9 unlock after drop", unlocked, 1);

    // R7: software-interrupt entry after a normal reset
    doReset(1'b0, 1'b1);
    check(monActive == 1'b0, "R7 off before swi", monActive, 0);
    strapOk = 1'b1; swiReq = 1'b1; @(negedge clk); swiReq = 1'b0;
    check(monActive == 1'b1, "R7 swi entry", monActive, 1);
    check(vecPage == 8'hFE, "R4 page after swi", vecPage, 8'hFE);
    for (int i = 0; i < 8; i++) sendByte(keyByte(i), 1'b1);
    repeat (BRK_CYC + 20) @(negedge clk);
    check(ready == 1'b1 && unlocked == 1'b1, "R8 swi unlock", unlocked, 1);

    // R8: reset clears unlock
    doReset(1'b1, 1'b1);
    check(unlocked == 1'b0 && ready == 1'b0, "R8 cleared by reset", unlocked, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule